// File: doc/BRIEF.md
# Integer ALU for a 64-bit core, with 32-bit word forms

This block is the single-cycle integer datapath of a 64-bit RISC-style execution stage. It takes two register-width operands, a 4-bit operation code and a 3-bit branch-condition code. From these it returns a result of the same width and a branch-taken flag. Both outputs are pure functions of the present inputs: there is no register anywhere in the block. The surrounding pipeline captures them in whichever stage holds this unit.

The result side covers wrapping add and subtract, the three bitwise logic operations, and left, logical right and arithmetic right shifts. It also covers signed and unsigned set-less-than. When the width parameter is 64 there are five extra word forms: add, subtract, shift left, logical shift right and arithmetic shift right. Each one works on the low 32 bits of the operands and sign-extends its 32-bit answer to the full width. The branch side compares the two operands for equality and for signed and unsigned ordering.

A parameter selects a 32-bit or 64-bit build. In a 32-bit build the word-form codes are illegal and yield zero. Immediate forms need no separate hardware: the decoder sign-extends the immediate and presents it as the second operand. For example, an unsigned set-less-than against an immediate of 1 yields 1 exactly when the first operand is zero.

Top module: `rv_int_alu`

## Requirements
- R1: Codes 0 (add) and 1 (subtract, first operand minus second) return the low XLEN bits of the exact result, with overflow discarded.
- R2: Codes 9 (AND), 8 (OR) and 5 (XOR) return the bitwise combination of the two full-width operands.
- R3: Codes 2 (shift left), 6 (logical shift right) and 7 (arithmetic shift right) shift the first operand by the amount in the low log2(XLEN) bits of the second operand, which are bits [5:0] when XLEN is 64. Higher bits of the second operand have no effect. The arithmetic form fills vacated bits with the original bit XLEN-1.
- R4: Code 3 (signed) and code 4 (unsigned) return 1 when the first operand is less than the second and 0 otherwise, with all upper result bits zero.
- R5: Codes 10 (word add) and 11 (word subtract) compute on operand bits [31:0] only and return the 32-bit result sign-extended from its bit 31.
- R6: Codes 12 (word shift left), 13 (word logical right) and 14 (word arithmetic right) shift operand bits [31:0] by second-operand bits [4:0] only, so bit 5 and above have no effect. The 32-bit result is sign-extended from its bit 31, and the arithmetic form fills from operand bit 31.
- R7: Condition code 0 asserts the taken flag when the operands are equal, and condition code 1 asserts it when they differ.
- R8: Condition codes 4 and 5 give signed less-than and signed greater-or-equal, and codes 6 and 7 give unsigned less-than and unsigned greater-or-equal.
- R9: Operation code 15 returns zero, condition codes 2 and 3 never assert the taken flag, and in a 32-bit build the codes 10 to 14 return zero.
- R10: Result and taken flag follow the inputs within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code selecting the result function |
| cond_i | input | 3 | Branch condition code |
| a_i | input | XLEN | First operand |
| b_i | input | XLEN | Second operand, or sign-extended immediate |
| result_o | output | XLEN | Operation result |
| taken_o | output | 1 | Branch condition holds |

## Verification
Adds and subtracts are run across the all-ones/zero boundary, so that a missing wrap or a swapped operand order shows up. Shifts use amounts of 0, 63 and values whose bits above the amount field are set. This separates a correct amount mask from one that is too narrow or too wide, and the arithmetic shift of a negative value is told apart from the logical shift. The word forms get operands with junk in the upper half and results whose bit 31 is set. A missing sign extension, or upper-half input leaking into the result, therefore changes the value seen. The compare and branch patterns pair a negative value with a small positive value, and also use equal operands, so that signed and unsigned ordering, strict and non-strict ordering, and the reserved codes each give a distinct answer.

// File: rtl/ialu_pkg.sv
`timescale 1ns/1ps
package ialu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_SLL  = 4'd2,
      OP_SLT  = 4'd3,
      OP_SLTU = 4'd4,
      OP_XOR  = 4'd5,
      OP_SRL  = 4'd6,
      OP_SRA  = 4'd7,
      OP_OR   = 4'd8,
      OP_AND  = 4'd9,
      OP_ADDW = 4'd10,
      OP_SUBW = 4'd11,
      OP_SLLW = 4'd12,
      OP_SRLW = 4'd13,
      OP_SRAW = 4'd14,
      OP_NONE = 4'd15
   } alu_op_e;

   typedef enum logic [2:0] {
      BR_EQ   = 3'd0,
      BR_NE   = 3'd1,
      BR_RSV2 = 3'd2,
      BR_RSV3 = 3'd3,
      BR_LT   = 3'd4,
      BR_GE   = 3'd5,
      BR_LTU  = 3'd6,
      BR_GEU  = 3'd7
   } br_cond_e;

   localparam int unsigned WORD_W = 32;

   function automatic logic is_word_op(alu_op_e op);
      return (op == OP_ADDW) || (op == OP_SUBW) || (op == OP_SLLW) ||
             (op == OP_SRLW) || (op == OP_SRAW);
   endfunction

   function automatic logic is_sub_op(alu_op_e op);
      return (op == OP_SUB) || (op == OP_SUBW);
   endfunction

endpackage

// File: rtl/ialu_addsub.sv
`timescale 1ns/1ps
module ialu_addsub #(
   parameter int unsigned XLEN = 64
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic            sub_i,
   output logic [XLEN-1:0] sum_o,
   output logic [XLEN-1:0] wsum_o
);
   import ialu_pkg::*;

   logic [XLEN-1:0] b_eff;

   // One carry chain serves both widths: the low 32 bits of a full-width
   // sum equal the 32-bit sum of the low halves.
   assign b_eff = sub_i ? ~b_i : b_i;
   assign sum_o = a_i + b_eff + {{(XLEN-1){1'b0}}, sub_i};

   generate
      if (XLEN > WORD_W) begin : g_word
         logic [WORD_W-1:0] lo;
         assign lo     = sum_o[WORD_W-1:0];
         assign wsum_o = {{(XLEN-WORD_W){lo[WORD_W-1]}}, lo};
      end else begin : g_noword
         assign wsum_o = '0;
      end
   endgenerate

endmodule

// File: rtl/ialu_shift.sv
`timescale 1ns/1ps
module ialu_shift #(
   parameter int unsigned XLEN = 64,
   localparam int unsigned SHW = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [SHW-1:0]  shamt_i,
   output logic [XLEN-1:0] sll_o,
   output logic [XLEN-1:0] srl_o,
   output logic [XLEN-1:0] sra_o,
   output logic [XLEN-1:0] sllw_o,
   output logic [XLEN-1:0] srlw_o,
   output logic [XLEN-1:0] sraw_o
);
   import ialu_pkg::*;

   assign sll_o = a_i << shamt_i;
   assign srl_o = a_i >> shamt_i;
   assign sra_o = $signed(a_i) >>> shamt_i;

   generate
      if (XLEN > WORD_W) begin : g_word
         localparam int unsigned WSHW = $clog2(WORD_W);
         logic [WORD_W-1:0] lo;
         logic [WSHW-1:0]   sh;
         logic [WORD_W-1:0] l_w, r_w, ra_w;

         assign lo   = a_i[WORD_W-1:0];
         assign sh   = shamt_i[WSHW-1:0];
         assign l_w  = lo << sh;
         assign r_w  = lo >> sh;
         assign ra_w = $signed(lo) >>> sh;

         assign sllw_o = {{(XLEN-WORD_W){l_w[WORD_W-1]}},  l_w};
         assign srlw_o = {{(XLEN-WORD_W){r_w[WORD_W-1]}},  r_w};
         assign sraw_o = {{(XLEN-WORD_W){ra_w[WORD_W-1]}}, ra_w};
      end else begin : g_noword
         assign sllw_o = '0;
         assign srlw_o = '0;
         assign sraw_o = '0;
      end
   endgenerate

endmodule

// File: rtl/ialu_cmp.sv
`timescale 1ns/1ps
module ialu_cmp #(
   parameter int unsigned XLEN = 64
) (
   input  logic [XLEN-1:0]          a_i,
   input  logic [XLEN-1:0]          b_i,
   input  ialu_pkg::br_cond_e       cond_i,
   output logic                     lt_s_o,
   output logic                     lt_u_o,
   output logic                     taken_o
);
   import ialu_pkg::*;

   logic eq;
   logic sa, sb;

   assign eq     = (a_i == b_i);
   assign lt_u_o = (a_i < b_i);
   assign sa     = a_i[XLEN-1];
   assign sb     = b_i[XLEN-1];
   // Differing signs decide on their own; same signs reuse the unsigned compare.
   assign lt_s_o = (sa != sb) ? sa : lt_u_o;

   always_comb begin
      case (cond_i)
         BR_EQ:   taken_o = eq;
         BR_NE:   taken_o = !eq;
         BR_LT:   taken_o = lt_s_o;
         BR_GE:   taken_o = !lt_s_o;
         BR_LTU:  taken_o = lt_u_o;
         BR_GEU:  taken_o = !lt_u_o;
         default: taken_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/rv_int_alu.sv
`timescale 1ns/1ps
module rv_int_alu #(
   parameter int unsigned XLEN = 64
) (
   input  logic [3:0]      op_i,
   input  logic [2:0]      cond_i,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic [XLEN-1:0] result_o,
   output logic            taken_o
);
   import ialu_pkg::*;

   localparam int unsigned SHW      = $clog2(XLEN);
   localparam bit          HAS_WORD = (XLEN > WORD_W);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("rv_int_alu: XLEN must be 32 or 64");
      end
   endgenerate

   alu_op_e  opc;
   br_cond_e brc;
   assign opc = alu_op_e'(op_i);
   assign brc = br_cond_e'(cond_i);

   logic [XLEN-1:0] sum, wsum;
   logic [XLEN-1:0] sll, srl, sra, sllw, srlw, sraw;
   logic            lt_s, lt_u;

   ialu_addsub #(.XLEN(XLEN)) u_addsub (
      .a_i    (a_i),
      .b_i    (b_i),
      .sub_i  (is_sub_op(opc)),
      .sum_o  (sum),
      .wsum_o (wsum)
   );

   ialu_shift #(.XLEN(XLEN)) u_shift (
      .a_i     (a_i),
      .shamt_i (b_i[SHW-1:0]),
      .sll_o   (sll),
      .srl_o   (srl),
      .sra_o   (sra),
      .sllw_o  (sllw),
      .srlw_o  (srlw),
      .sraw_o  (sraw)
   );

   ialu_cmp #(.XLEN(XLEN)) u_cmp (
      .a_i     (a_i),
      .b_i     (b_i),
      .cond_i  (brc),
      .lt_s_o  (lt_s),
      .lt_u_o  (lt_u),
      .taken_o (taken_o)
   );

   logic [XLEN-1:0] full_res;
   logic [XLEN-1:0] word_res;

   always_comb begin
      case (opc)
         OP_ADD, OP_SUB: full_res = sum;
         OP_AND:         full_res = a_i & b_i;
         OP_OR:          full_res = a_i | b_i;
         OP_XOR:         full_res = a_i ^ b_i;
         OP_SLL:         full_res = sll;
         OP_SRL:         full_res = srl;
         OP_SRA:         full_res = sra;
         OP_SLT:         full_res = {{(XLEN-1){1'b0}}, lt_s};
         OP_SLTU:        full_res = {{(XLEN-1){1'b0}}, lt_u};
         default:        full_res = '0;
      endcase
   end

   always_comb begin
      case (opc)
         OP_ADDW, OP_SUBW: word_res = wsum;
         OP_SLLW:          word_res = sllw;
         OP_SRLW:          word_res = srlw;
         OP_SRAW:          word_res = sraw;
         default:          word_res = '0;
      endcase
   end

   generate
      if (HAS_WORD) begin : g_mux_word
         assign result_o = is_word_op(opc) ? word_res : full_res;
      end else begin : g_mux_full
         assign result_o = is_word_op(opc) ? '0 : full_res;
      end
   endgenerate

endmodule

// File: rtl/ialu_chk.sv
`timescale 1ns/1ps
module ialu_chk #(
   parameter int unsigned XLEN = 64
) (
   input logic [3:0]      op_i,
   input logic [2:0]      cond_i,
   input logic [XLEN-1:0] a_i,
   input logic [XLEN-1:0] b_i,
   input logic [XLEN-1:0] result_o,
   input logic            taken_o
);
   localparam int unsigned SHW = $clog2(XLEN);

   always_comb begin
      // R4: compare results are a single bit
      if (op_i == 4'd3 || op_i == 4'd4)
         assert_slt_onebit_R4: assert (result_o[XLEN-1:1] == '0);
      // R3: zero shift amount passes the operand through
      if ((op_i == 4'd2 || op_i == 4'd6 || op_i == 4'd7) && b_i[SHW-1:0] == '0)
         assert_shift_zero_R3: assert (result_o == a_i);
      // R2: AND result never sets a bit absent from either operand
      if (op_i == 4'd9)
         assert_and_subset_R2: assert (((result_o & ~a_i) | (result_o & ~b_i)) == '0);
      // R7: equality condition agrees with operand equality
      if (cond_i == 3'd0)
         assert_beq_match_R7: assert (taken_o == (a_i == b_i));
      // R9: reserved codes
      if (cond_i == 3'd2 || cond_i == 3'd3)
         assert_rsv_cond_R9: assert (!taken_o);
      if (op_i == 4'd15)
         assert_rsv_op_R9: assert (result_o == '0);
   end

   generate
      if (XLEN > 32) begin : g_word_chk
         always_comb begin
            // R5: word add/sub upper half replicates bit 31
            if (op_i == 4'd10 || op_i == 4'd11)
               assert_wadd_sext_R5: assert (result_o[XLEN-1:32] == {(XLEN-32){result_o[31]}});
            // R6: word shift upper half replicates bit 31
            if (op_i == 4'd12 || op_i == 4'd13 || op_i == 4'd14)
               assert_wshift_sext_R6: assert (result_o[XLEN-1:32] == {(XLEN-32){result_o[31]}});
         end
      end else begin : g_word_chk32
         always_comb begin
            // R9: word codes illegal in a 32-bit build
            if (op_i >= 4'd10 && op_i <= 4'd14)
               assert_word_illegal_R9: assert (result_o == '0);
         end
      end
   endgenerate

endmodule

bind rv_int_alu ialu_chk #(.XLEN(XLEN)) u_chk (
   .op_i     (op_i),
   .cond_i   (cond_i),
   .a_i      (a_i),
   .b_i      (b_i),
   .result_o (result_o),
   .taken_o  (taken_o)
);

// File: tb/rv_int_alu_tb.sv
`timescale 1ns/1ps
module rv_int_alu_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;  // 200 MHz

   logic [3:0]  op   = 4'd0;
   logic [2:0]  cond = 3'd0;
   logic [63:0] a    = '0;
   logic [63:0] b    = '0;
   logic [63:0] res;
   logic        taken;

   logic [3:0]  op32 = 4'd0;
   logic [31:0] a32  = '0;
   logic [31:0] b32  = '0;
   logic [31:0] res32;
   logic        taken32;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   rv_int_alu #(.XLEN(64)) u_dut (
      .op_i(op), .cond_i(cond), .a_i(a), .b_i(b),
      .result_o(res), .taken_o(taken)
   );

   rv_int_alu #(.XLEN(32)) u_dut32 (
      .op_i(op32), .cond_i(3'd0), .a_i(a32), .b_i(b32),
      .result_o(res32), .taken_o(taken32)
   );

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_op(logic [3:0] o, logic [63:0] x, logic [63:0] y);
      @(negedge clk);
      op = o; a = x; b = y;
      #1;
   endtask

   task automatic run_br(logic [2:0] c, logic [63:0] x, logic [63:0] y);
      @(negedge clk);
      cond = c; a = x; b = y;
      #1;
   endtask

   task automatic t_reset;
      check("R10 reset result", res, 64'h0);
      check("R7 reset taken", {63'b0, taken}, 64'h1);
   endtask

   task automatic t_addsub;
      run_op(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
      check("R1 add wrap", res, 64'h0);
      run_op(4'd0, 64'd5, 64'd7);
      check("R1 add", res, 64'd12);
      run_op(4'd1, 64'h0, 64'h1);
      check("R1 sub wrap", res, 64'hFFFF_FFFF_FFFF_FFFF);
      run_op(4'd1, 64'h10, 64'h3);
      check("R1 sub order", res, 64'hD);
   endtask

   task automatic t_logic;
      run_op(4'd9, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00);
      check("R2 and", res, 64'hF000_F000_F000_F000);
      run_op(4'd8, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00);
      check("R2 or", res, 64'hFFF0_FFF0_FFF0_FFF0);
      run_op(4'd5, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00);
      check("R2 xor", res, 64'h0FF0_0FF0_0FF0_0FF0);
   endtask

   task automatic t_shift;
      run_op(4'd2, 64'h1, 64'd63);
      check("R3 sll 63", res, 64'h8000_0000_0000_0000);
      run_op(4'd2, 64'h1, 64'h44);
      check("R3 sll high bits ignored", res, 64'h10);
      run_op(4'd6, 64'h8000_0000_0000_0000, 64'd63);
      check("R3 srl 63", res, 64'h1);
      run_op(4'd7, 64'h8000_0000_0000_0000, 64'd4);
      check("R3 sra negative", res, 64'hF800_0000_0000_0000);
      run_op(4'd7, 64'h4000_0000_0000_0000, 64'd1);
      check("R3 sra positive", res, 64'h2000_0000_0000_0000);
      run_op(4'd7, 64'h8123_4567_89AB_CDEF, 64'h0);
      check("R3 sra zero", res, 64'h8123_4567_89AB_CDEF);
   endtask

   task automatic t_slt;
      run_op(4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
      check("R4 slt neg<pos", res, 64'h1);
      run_op(4'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
      check("R4 sltu big", res, 64'h0);
      run_op(4'd3, 64'h1, 64'h1);
      check("R4 slt equal", res, 64'h0);
      run_op(4'd4, 64'h0, 64'h1);
      check("R4 sltu zero test true", res, 64'h1);
      run_op(4'd4, 64'h5, 64'h1);
      check("R4 sltu zero test false", res, 64'h0);
   endtask

   task automatic t_word_addsub;
      run_op(4'd10, 64'h7FFF_FFFF, 64'h1);
      check("R5 addw sext", res, 64'hFFFF_FFFF_8000_0000);
      run_op(4'd10, 64'h1234_5678_0000_0001, 64'h9);
      check("R5 addw upper ignored", res, 64'hA);
      run_op(4'd11, 64'h0, 64'h1);
      check("R5 subw neg", res, 64'hFFFF_FFFF_FFFF_FFFF);
      run_op(4'd11, 64'h1_0000_0005, 64'h5);
      check("R5 subw upper ignored", res, 64'h0);
   endtask

   task automatic t_word_shift;
      run_op(4'd12, 64'h1, 64'd31);
      check("R6 sllw sext", res, 64'hFFFF_FFFF_8000_0000);
      run_op(4'd12, 64'h1, 64'h21);
      check("R6 sllw bit5 ignored", res, 64'h2);
      run_op(4'd13, 64'hFFFF_FFFF_8000_0000, 64'd31);
      check("R6 srlw", res, 64'h1);
      run_op(4'd13, 64'h8000_0000, 64'd0);
      check("R6 srlw zero sext", res, 64'hFFFF_FFFF_8000_0000);
      run_op(4'd14, 64'h8000_0000, 64'd4);
      check("R6 sraw fill", res, 64'hFFFF_FFFF_F800_0000);
      run_op(4'd14, 64'hFFFF_FFFF_4000_0000, 64'd1);
      check("R6 sraw upper ignored", res, 64'h2000_0000);
   endtask

   task automatic t_branch;
      run_br(3'd0, 64'h1234, 64'h1234);
      check("R7 eq true", {63'b0, taken}, 64'h1);
      run_br(3'd0, 64'h8000_0000_0000_1234, 64'h1234);
      check("R7 eq msb differs", {63'b0, taken}, 64'h0);
      run_br(3'd1, 64'h8000_0000_0000_1234, 64'h1234);
      check("R7 ne true", {63'b0, taken}, 64'h1);
      run_br(3'd1, 64'h1234, 64'h1234);
      check("R7 ne false", {63'b0, taken}, 64'h0);
      run_br(3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
      check("R8 lt signed", {63'b0, taken}, 64'h1);
      run_br(3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
      check("R8 ge signed", {63'b0, taken}, 64'h0);
      run_br(3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
      check("R8 ltu", {63'b0, taken}, 64'h0);
      run_br(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
      check("R8 geu", {63'b0, taken}, 64'h1);
      run_br(3'd4, 64'h77, 64'h77);
      check("R8 lt equal", {63'b0, taken}, 64'h0);
      run_br(3'd5, 64'h77, 64'h77);
      check("R8 ge equal", {63'b0, taken}, 64'h1);
      run_br(3'd7, 64'h77, 64'h77);
      check("R8 geu equal", {63'b0, taken}, 64'h1);
   endtask

   task automatic t_reserved;
      run_op(4'd15, 64'hDEAD_BEEF, 64'h1);
      check("R9 op 15 zero", res, 64'h0);
      run_br(3'd2, 64'h5, 64'h5);
      check("R9 cond 2", {63'b0, taken}, 64'h0);
      run_br(3'd3, 64'h5, 64'h6);
      check("R9 cond 3", {63'b0, taken}, 64'h0);
   endtask

   task automatic t_narrow;
      @(negedge clk);
      op32 = 4'd10; a32 = 32'h7FFF_FFFF; b32 = 32'h1;
      #1;
      check("R9 xlen32 word op zero", {32'b0, res32}, 64'h0);
      op32 = 4'd0; a32 = 32'hFFFF_FFFF; b32 = 32'h1;
      #1;
      check("R1 xlen32 add wrap", {32'b0, res32}, 64'h0);
      op32 = 4'd2; a32 = 32'h1; b32 = 32'h21;
      #1;
      check("R3 xlen32 shift amount 5 bits", {32'b0, res32}, 64'h2);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      op = 4'd0; a = 64'd100; b = 64'd23;
      #0.5;
      check("R10 first value", res, 64'd123);
      b = 64'd1;
      #0.5;
      check("R10 follows input without edge", res, 64'd101);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_addsub();
      t_logic();
      t_shift();
      t_slt();
      t_word_addsub();
      t_word_shift();
      t_branch();
      t_reserved();
      t_narrow();
      t_same_cycle();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule